// File: doc/BRIEF.md
# Gated Synchronous Clock Divider Bank

This block derives three slower clocks from one input clock: one at half, one at a quarter and one at an eighth of the input rate. All three come from the bits of a single counter that advances on the rising edge of the input clock. Because of this, every edge that two outputs have in common falls on the same input edge.

An active-high enable input freezes the bank. That input is registered on the falling edge of the input clock, so the counter is only ever stopped or restarted while the clock is low. As a result, no output phase is ever cut short. An active-high master reset clears the counter at once, whatever the clock is doing. Its release passes through a two-stage falling-edge start chain. Several banks that leave reset together therefore begin counting on the same rising edge. How many edges pass before counting starts depends on the clock level at the moment of release.

Top module: `gsync_div_bank`

## Requirements
- R1: While running, `q_div2` changes at every rising edge of `clk`, `q_div4` at every second and `q_div8` at every fourth, giving periods of 2, 4 and 8 input cycles.
- R2: The value {q_div8, q_div4, q_div2}, read as a 3-bit binary number, goes up by exactly one (modulo 8) at each rising edge on which the bank runs, and stays the same otherwise.
- R3: While `mr` is 1, all three outputs are 0 without waiting for a clock edge, whatever `clk` and `en` are doing.
- R4: When `mr` falls while `clk` is high, the outputs read 0 after the first rising edge that follows and read 1 after the second one.
- R5: When `mr` falls while `clk` is low, the outputs read 0 after the first two rising edges that follow and read 1 after the third one.
- R6: `en` is sampled at the falling edge of `clk`. When it is 1 at a falling edge, the next rising edge leaves the outputs unchanged. A rising edge before that falling edge still advances the count.
- R7: When `en` is 0 at a falling edge after a freeze, counting resumes at the next rising edge from the held value, and the outputs keep their relationship to each other.
- R8: A pulse on `en` that begins and ends between two falling edges of `clk` has no effect on the count.
- R9: Outside of reset, the outputs change only at rising edges of `clk`, never at a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| en | input | 1 | Freeze request, active high, sampled on the falling edge of clk |
| mr | input | 1 | Master reset, active high, asynchronous assertion |
| q_div2 | output | 1 | Input clock divided by two |
| q_div4 | output | 1 | Input clock divided by four |
| q_div8 | output | 1 | Input clock divided by eight |

## Verification
The bench builds the bank with its defaults: a 3-bit counter and a 2-stage start chain. With these values the whole counter state space of eight values is walked around several full laps. This shows every carry pattern, including the wrap from 7 to 0, where all three outputs move on one edge. The small start depth keeps both release cases short enough to check cycle by cycle. Freeze requests, resumes and short enable pulses are placed in both the high and the low phase of the clock.

// File: rtl/gsync_div_pkg.sv
`timescale 1ns/1ps
package gsync_div_pkg;
  // number of divided outputs taken from the counter
  localparam int unsigned OUT_TAPS = 3;

  // gating state seen by the counter, both produced on the falling edge
  typedef struct packed {
    logic started;
    logic frozen;
  } gate_t;
endpackage

// File: rtl/gsync_div_start.sv
`timescale 1ns/1ps
// Falling-edge start chain: reset release ripples through DEPTH stages
// before the counter is allowed to advance.
module gsync_div_start #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic mr,
  output logic started
);
  logic [DEPTH-1:0] sh_q;
  logic [DEPTH-1:0] sh_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb sh_d = 1'b1;
    end else begin : g_chain
      always_comb sh_d = {sh_q[DEPTH-2:0], 1'b1};
    end
  endgenerate

  always_ff @(negedge clk or posedge mr) begin
    if (mr) sh_q <= '0;
    else    sh_q <= sh_d;
  end

  assign started = sh_q[DEPTH-1];

  // once started, the chain stays started until the next reset
  AST_START_HOLD: assert property (@(negedge clk) disable iff (mr)
    started |=> started); // R4

  generate
    if (DEPTH >= 2) begin : g_chain_chk
      AST_START_CHAIN: assert property (@(negedge clk) disable iff (mr)
        sh_q[DEPTH-1] |-> $past(sh_q[DEPTH-2])); // R5
    end
  endgenerate
endmodule

// File: rtl/gsync_div_hold.sv
`timescale 1ns/1ps
// Falling-edge capture of the freeze request.
module gsync_div_hold (
  input  logic clk,
  input  logic mr,
  input  logic en,
  output logic frozen
);
  logic frz_q;
  logic frz_d;

  always_comb frz_d = en;

  always_ff @(negedge clk or posedge mr) begin
    if (mr) frz_q <= 1'b0;
    else    frz_q <= frz_d;
  end

  assign frozen = frz_q;

  AST_HOLD_TRACK: assert property (@(negedge clk) disable iff (mr)
    $past(!mr) |-> (frozen == $past(en))); // R6
endmodule

// File: rtl/gsync_div_counter.sv
`timescale 1ns/1ps
// Rising-edge binary counter with an explicit advance enable.
module gsync_div_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         mr,
  input  logic         adv,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] carry;

  assign carry[0] = adv;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign cnt_d[i] = cnt_q[i] ^ carry[i];
      if (i < W - 1) begin : g_carry
        assign carry[i+1] = carry[i] & cnt_q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge mr) begin
    if (mr)       cnt_q <= '0;
    else if (adv) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (mr)
    (cnt_q == $past(cnt_q)) || (cnt_q == W'($past(cnt_q) + 1'b1))); // R2

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (mr)
    !adv |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/gsync_div_bank.sv
`timescale 1ns/1ps
module gsync_div_bank
  import gsync_div_pkg::*;
#(
  parameter int unsigned CNT_W       = OUT_TAPS,
  parameter int unsigned START_DEPTH = 2
) (
  input  logic clk,
  input  logic en,
  input  logic mr,
  output logic q_div2,
  output logic q_div4,
  output logic q_div8
);
  gate_t            gate;
  logic             adv;
  logic [CNT_W-1:0] cnt;

  gsync_div_start #(.DEPTH(START_DEPTH)) u_start (
    .clk     (clk),
    .mr      (mr),
    .started (gate.started)
  );

  gsync_div_hold u_hold (
    .clk    (clk),
    .mr     (mr),
    .en     (en),
    .frozen (gate.frozen)
  );

  // gate terms only change on the falling edge, so adv is steady
  // across every rising edge
  assign adv = gate.started & ~gate.frozen;

  gsync_div_counter #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .mr  (mr),
    .adv (adv),
    .cnt (cnt)
  );

  assign q_div2 = cnt[0];
  assign q_div4 = cnt[1];
  assign q_div8 = cnt[2];

  AST_OUT_CLEAR: assert property (@(posedge clk)
    mr |-> ({q_div8, q_div4, q_div2} == 3'b000)); // R3
endmodule

// File: tb/sim_gsync_div_bank.sv
`timescale 1ns/1ps
module sim_gsync_div_bank;
  logic clk;
  logic en;
  logic mr;
  logic q_div2, q_div4, q_div8;

  int n_chk = 0;
  int n_err = 0;
  logic [2:0] exp_v;

  gsync_div_bank u0 (
    .clk    (clk),
    .en     (en),
    .mr     (mr),
    .q_div2 (q_div2),
    .q_div4 (q_div4),
    .q_div8 (q_div8)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [2:0] obs();
    return {q_div8, q_div4, q_div2};
  endfunction

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic rise();
    @(posedge clk); #1;
  endtask

  task automatic fall();
    @(negedge clk); #1;
  endtask

  initial begin
    #100000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    en = 1'b0;
    mr = 1'b0;
    #1 mr = 1'b1;
    repeat (3) rise();
    chk("R3 reset state", obs(), 3'd0);
    en = 1'b1;
    rise();
    chk("R3 reset with en high", obs(), 3'd0);
    en = 1'b0;

    // release while clk high
    mr = 1'b0;
    rise();
    chk("R4 first edge after release", obs(), 3'd0);
    rise();
    chk("R4 second edge after release", obs(), 3'd1);
    exp_v = 3'd1;

    // several laps of all eight states
    for (int i = 0; i < 24; i++) begin
      rise();
      exp_v = exp_v + 3'd1;
      chk("R2 count step", obs(), exp_v);
      chk("R1 q_div2 phase", {2'b00, q_div2}, {2'b00, exp_v[0]});
      chk("R1 q_div8 phase", {2'b00, q_div8}, {2'b00, exp_v[2]});
      fall();
      chk("R9 no change at falling edge", obs(), exp_v);
    end

    // freeze requested in the high phase
    rise();
    exp_v = exp_v + 3'd1;
    chk("R2 before freeze", obs(), exp_v);
    en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      rise();
      chk("R6 held while frozen", obs(), exp_v);
    end
    en = 1'b0;
    rise();
    exp_v = exp_v + 3'd1;
    chk("R7 resume from held value", obs(), exp_v);

    // freeze requested in the low phase
    fall();
    en = 1'b1;
    rise();
    exp_v = exp_v + 3'd1;
    chk("R6 edge before capture still counts", obs(), exp_v);
    rise();
    chk("R6 held after capture", obs(), exp_v);
    rise();
    chk("R6 still held", obs(), exp_v);
    fall();
    en = 1'b0;
    rise();
    chk("R7 held until next falling edge", obs(), exp_v);
    rise();
    exp_v = exp_v + 3'd1;
    chk("R7 resumed", obs(), exp_v);
    rise();
    exp_v = exp_v + 3'd1;
    chk("R7 keeps counting", obs(), exp_v);

    // short pulses that miss every falling edge
    en = 1'b1;
    #1 en = 1'b0;
    rise();
    exp_v = exp_v + 3'd1;
    chk("R8 high-phase pulse ignored", obs(), exp_v);
    fall();
    en = 1'b1;
    #1 en = 1'b0;
    rise();
    exp_v = exp_v + 3'd1;
    chk("R8 low-phase pulse ignored", obs(), exp_v);

    // make sure the count is nonzero, then reset asynchronously
    if (exp_v == 3'd0) begin
      rise();
      exp_v = exp_v + 3'd1;
      chk("R2 step before reset", obs(), exp_v);
    end
    fall();
    mr = 1'b1;
    #0.5;
    chk("R3 asynchronous clear", obs(), 3'd0);
    en = 1'b1;
    rise();
    chk("R3 held with en high", obs(), 3'd0);
    en = 1'b0;

    // release while clk low
    fall();
    mr = 1'b0;
    rise();
    chk("R5 first edge after release", obs(), 3'd0);
    rise();
    chk("R5 second edge after release", obs(), 3'd0);
    rise();
    chk("R5 third edge after release", obs(), 3'd1);
    exp_v = 3'd1;
    for (int i = 0; i < 10; i++) begin
      rise();
      exp_v = exp_v + 3'd1;
      chk("R2 count after second release", obs(), exp_v);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule